// File: doc/BRIEF.md
# Disk ID Field Capture Engine

This block carries out the read-address step of a floppy disk controller. It works on a stream of disk bytes that a data separator upstream has already decoded, and each byte comes with a flag that marks it as an address mark. When a command strobe is accepted, the engine raises busy and watches the stream for the next ID field header. In double-density (MFM) mode a header is three flagged A1 bytes followed by a flagged FE. In single-density (FM) mode it is a flagged FE alone.

Once a header is seen, the six bytes that follow are passed to the host one at a time through a data register, with a data request for each byte. The order is track, side, sector number, length code, CRC high and CRC low. A CRC-16 (polynomial 0x1021, preset 0xFFFF) runs over the sync bytes, the mark and the whole field, and a wrong residue sets a CRC-error flag. The captured track byte is copied into a sector register so the host can compare it. The operation ends with busy dropping and an interrupt rising in the same cycle. If no header arrives within a set number of index pulses, the engine reports record-not-found.

Top module: `idfield_capture`

## Requirements
- R1: A `cmd_go` pulse while idle sets busy (`status[0]`) on the next edge and clears `intrq`, `drq`, lost-data, CRC-error and record-not-found.
- R2: A header is recognised only by a flagged FE byte. In MFM mode that byte must directly follow three consecutive flagged A1 bytes. Any other byte breaks the A1 run. A header with only two A1 bytes loads nothing into the data register.
- R3: After a header, the next six valid bytes are loaded into `data_reg` in arrival order, and each load sets `drq`.
- R4: A pulse on `host_rd_data` or `host_wr_data` clears `drq` and `status[1]` unless a new byte loads in the same cycle. `status[1]` always equals `drq`.
- R5: Lost-data (`status[2]`) is set when a byte loads while `drq` is still set and no host access happens in that cycle. A host access in the same cycle as the load prevents it.
- R6: CRC-error (`status[3]`) is set at the end if the CRC-16 residue after the sixth byte is non-zero. All six bytes are still delivered.
- R7: The first ID byte (track) is written into `sector_reg`. `sector_reg` changes at no other time.
- R8: When the operation ends, busy clears and `intrq` sets on the same edge. `intrq` then holds until the next accepted command.
- R9: If `MAX_REVS` index pulses (default 6) pass while hunting, record-not-found (`status[4]`) sets, busy clears and `intrq` sets.
- R10: A `cmd_go` pulse while busy is ignored and does not restart the index count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Start strobe for the operation |
| mfm_mode | input | 1 | 1 = double density (A1 sync), 0 = single density |
| byte_valid | input | 1 | A decoded disk byte is present this cycle |
| byte_data | input | 8 | Decoded disk byte |
| byte_mark | input | 1 | The byte is an address mark |
| index_pulse | input | 1 | One-cycle pulse per disk revolution |
| host_rd_data | input | 1 | Host read of the data register |
| host_wr_data | input | 1 | Host write of the data register |
| data_reg | output | 8 | Data register holding the latest ID byte |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| sector_reg | output | 8 | Sector register loaded with the captured track byte |
| status | output | 5 | {not-found, crc-error, lost-data, drq, busy} |

## Verification
Two functions can meet in the same clock edge: the host taking a byte from the data register, and the next disk byte loading into it. The bench provokes this by raising `host_rd_data` in exactly the cycle that `byte_valid` carries the following ID byte. It then requires `drq` to remain set and lost-data to remain clear. A separate scenario skips the host read altogether and requires lost-data to set, which shows that the two cases are told apart.

// File: rtl/idf_pkg.sv
// Package: shared constants, controller state type and the CRC-16 byte step.
// Assumes MSB-first CRC with polynomial 0x1021 and no final inversion.
package idf_pkg;
    localparam int          ID_LEN    = 6;
    localparam int          SYNC_CNT  = 3;
    localparam logic [7:0]  SYNC_BYTE = 8'hA1;
    localparam logic [7:0]  ID_MARK   = 8'hFE;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_CAPT = 2'd2
    } idf_state_e;

    // Advance the CRC register by one byte, MSB first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction
endpackage

// File: rtl/idf_sync_detect.sv
// Module: spots an ID header in the flagged byte stream.
// Assumes one byte per byte_valid pulse. The A1 run count is held at zero while disabled.
module idf_sync_detect
    import idf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       mfm,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       byte_mark,
    output logic       id_start
);
    localparam int RUN_W = $clog2(SYNC_CNT + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(SYNC_CNT);

    logic [RUN_W-1:0] run_q;
    logic             is_sync;

    assign is_sync = byte_mark && (byte_data == SYNC_BYTE);

    // Count consecutive flagged A1 bytes, saturating at the sync length.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q <= '0;
        end else if (byte_valid) begin
            if (is_sync) run_q <= (run_q == RUN_FULL) ? RUN_FULL : run_q + 1'b1;
            else         run_q <= '0;
        end
    end

    // A flagged FE closes the header; in MFM only after a full A1 run.
    assign id_start = enable && byte_valid && byte_mark && (byte_data == ID_MARK)
                      && (!mfm || (run_q == RUN_FULL));
endmodule

// File: rtl/idf_crc_unit.sv
// Module: CRC-16 accumulator for the ID field.
// On seed it loads the value for the preset plus the sync bytes and mark already seen.
// On feed it absorbs one ID byte. residue_ok tells whether the current byte leaves a zero residue.
module idf_crc_unit
    import idf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic       mfm,
    input  logic       feed,
    input  logic [7:0] din,
    output logic       residue_ok
);
    logic [15:0] crc_q;
    logic [15:0] hdr_crc;

    // Header contribution: A1 x SYNC_CNT in MFM, then the FE mark.
    always_comb begin
        hdr_crc = CRC_INIT;
        if (mfm) begin
            for (int k = 0; k < SYNC_CNT; k++) hdr_crc = crc_step(hdr_crc, SYNC_BYTE);
        end
        hdr_crc = crc_step(hdr_crc, ID_MARK);
    end

    // Hold the running CRC of the field.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= CRC_INIT;
        else if (seed) crc_q <= hdr_crc;
        else if (feed) crc_q <= crc_step(crc_q, din);
    end

    assign residue_ok = (crc_step(crc_q, din) == 16'h0000);
endmodule

// File: rtl/idf_rev_timer.sv
// Module: counts index pulses while hunting and flags the pulse that reaches the limit.
// Assumes MAX_REVS >= 1. A clear restarts the count.
module idf_rev_timer #(
    parameter int MAX_REVS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic index_pulse,
    output logic expired
);
    localparam int REV_W = $clog2(MAX_REVS + 1);
    localparam logic [REV_W-1:0] LAST_REV = REV_W'(MAX_REVS - 1);

    logic [REV_W-1:0] revs_q;

    // Count index pulses seen while active.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)           revs_q <= '0;
        else if (active && index_pulse) revs_q <= revs_q + 1'b1;
    end

    assign expired = active && index_pulse && (revs_q == LAST_REV);
endmodule

// File: rtl/idfield_capture.sv
// Module: read-address engine. It hunts for an ID header, hands the six ID bytes
// to the host with a data request each, checks the CRC, copies the track byte into
// the sector register and ends with an interrupt.
// Assumes the input bytes are already decoded and at least one idle cycle apart.
module idfield_capture
    import idf_pkg::*;
#(
    parameter int MAX_REVS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic       mfm_mode,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       byte_mark,
    input  logic       index_pulse,
    input  logic       host_rd_data,
    input  logic       host_wr_data,
    output logic [7:0] data_reg,
    output logic       drq,
    output logic       intrq,
    output logic [7:0] sector_reg,
    output logic [4:0] status
);
    localparam int SLOT_W = $clog2(ID_LEN);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(ID_LEN - 1);

    idf_state_e        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic              lost_q, crc_err_q, rnf_q;
    logic              accept, hunting, take, host_acc;
    logic              id_start, expired, residue_ok;

    assign accept   = cmd_go && (state_q == ST_IDLE);
    assign hunting  = (state_q == ST_HUNT);
    assign take     = (state_q == ST_CAPT) && byte_valid;
    assign host_acc = host_rd_data || host_wr_data;

    idf_sync_detect u_sync (
        .clk(clk), .rst_n(rst_n), .enable(hunting), .mfm(mfm_mode),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_mark(byte_mark),
        .id_start(id_start)
    );

    idf_crc_unit u_crc (
        .clk(clk), .rst_n(rst_n), .seed(id_start), .mfm(mfm_mode),
        .feed(take), .din(byte_data), .residue_ok(residue_ok)
    );

    idf_rev_timer #(.MAX_REVS(MAX_REVS)) u_revs (
        .clk(clk), .rst_n(rst_n), .clear(accept), .active(hunting),
        .index_pulse(index_pulse), .expired(expired)
    );

    // Sequence the operation and update the flags it owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            slot_q     <= '0;
            lost_q     <= 1'b0;
            crc_err_q  <= 1'b0;
            rnf_q      <= 1'b0;
            intrq      <= 1'b0;
            data_reg   <= '0;
            sector_reg <= '0;
        end else if (accept) begin
            state_q   <= ST_HUNT;
            slot_q    <= '0;
            lost_q    <= 1'b0;
            crc_err_q <= 1'b0;
            rnf_q     <= 1'b0;
            intrq     <= 1'b0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (id_start) begin
                        state_q <= ST_CAPT;
                        slot_q  <= '0;
                    end else if (expired) begin
                        rnf_q   <= 1'b1;
                        intrq   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_CAPT: begin
                    if (byte_valid) begin
                        data_reg <= byte_data;
                        slot_q   <= slot_q + 1'b1;
                        if (drq && !host_acc) lost_q <= 1'b1;
                        if (slot_q == '0) sector_reg <= byte_data;
                        if (slot_q == LAST_SLOT) begin
                            crc_err_q <= !residue_ok;
                            intrq     <= 1'b1;
                            state_q   <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Data request: set by each byte load, cleared by host access or a new command.
    always_ff @(posedge clk) begin
        if (!rst_n)        drq <= 1'b0;
        else if (accept)   drq <= 1'b0;
        else if (take)     drq <= 1'b1;
        else if (host_acc) drq <= 1'b0;
    end

    assign status = {rnf_q, crc_err_q, lost_q, drq, (state_q != ST_IDLE)};
endmodule

// File: rtl/idf_checker.sv
// Module: temporal checks on the read-address engine, bound to every instance.
module idf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_go,
    input logic       byte_valid,
    input logic       host_rd_data,
    input logic       host_wr_data,
    input logic       drq,
    input logic       intrq,
    input logic [7:0] sector_reg,
    input logic [4:0] status
);
    // R8
    busy_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> intrq);

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !status[0]) |=> (status[0] && !intrq && !drq));

    // R4
    host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd_data || host_wr_data) && !byte_valid) |=> !drq);

    // R3
    drq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> $past(status[0]));

    // R7
    sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sector_reg) |-> $past(status[0]));

    // R9
    rnf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |-> !status[3]);
endmodule

bind idfield_capture idf_checker i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .byte_valid(byte_valid),
    .host_rd_data(host_rd_data), .host_wr_data(host_wr_data), .drq(drq),
    .intrq(intrq), .sector_reg(sector_reg), .status(status)
);

// File: tb/test_idfield_capture.sv
// Directed bench for the read-address engine. One task per scenario.
module test_idfield_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0, mfm_mode = 1'b1, byte_valid = 1'b0, byte_mark = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       index_pulse = 1'b0, host_rd_data = 1'b0, host_wr_data = 1'b0;
    logic [7:0] data_reg, sector_reg;
    logic       drq, intrq;
    logic [4:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    idfield_capture i_idfield_capture (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .mfm_mode(mfm_mode),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_mark(byte_mark),
        .index_pulse(index_pulse), .host_rd_data(host_rd_data), .host_wr_data(host_wr_data),
        .data_reg(data_reg), .drq(drq), .intrq(intrq), .sector_reg(sector_reg), .status(status)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb;
            fb = r[15] ^ d[7-b];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic start_cmd();
        @(negedge clk) cmd_go = 1'b1;
        @(negedge clk) cmd_go = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic m);
        @(negedge clk) begin byte_valid = 1'b1; byte_data = d; byte_mark = m; end
        @(negedge clk) begin byte_valid = 1'b0; byte_mark = 1'b0; end
    endtask

    task automatic host_read();
        @(negedge clk) host_rd_data = 1'b1;
        @(negedge clk) host_rd_data = 1'b0;
    endtask

    task automatic pulse_index();
        @(negedge clk) index_pulse = 1'b1;
        @(negedge clk) index_pulse = 1'b0;
    endtask

    // Build the six ID bytes with a correct or a corrupted CRC.
    task automatic make_field(input logic mfm, input logic [7:0] trk, input logic [7:0] sd,
                              input logic [7:0] sec, input logic [7:0] len, input bit bad,
                              output logic [7:0] f [6]);
        logic [15:0] c;
        c = 16'hFFFF;
        if (mfm) for (int k = 0; k < 3; k++) c = ref_crc(c, 8'hA1);
        c = ref_crc(c, 8'hFE);
        f[0] = trk; f[1] = sd; f[2] = sec; f[3] = len;
        for (int k = 0; k < 4; k++) c = ref_crc(c, f[k]);
        if (bad) c = c ^ 16'h0100;
        f[4] = c[15:8]; f[5] = c[7:0];
    endtask

    task automatic send_header(input logic mfm);
        if (mfm) for (int k = 0; k < 3; k++) send(8'hA1, 1'b1);
        send(8'hFE, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 reset status", 16'(status), 16'h0);
        check("R8 reset intrq", 16'(intrq), 16'h0);
        check("R7 reset sector_reg", 16'(sector_reg), 16'h0);
    endtask

    task automatic t_mfm_good();
        logic [7:0] f [6];
        mfm_mode = 1'b1;
        make_field(1'b1, 8'h27, 8'h01, 8'h05, 8'h02, 1'b0, f);
        start_cmd();
        check("R1 busy after accept", 16'(status[0]), 16'h1);
        send(8'h4E, 1'b0); send(8'h00, 1'b0);
        send_header(1'b1);
        for (int i = 0; i < 6; i++) begin
            send(f[i], 1'b0);
            check("R3 data_reg byte", 16'(data_reg), 16'(f[i]));
            check("R3 drq per byte", 16'(drq), 16'h1);
            check("R4 status1 mirrors drq", 16'(status[1]), 16'h1);
            if (i < 5) check("R8 busy during field", 16'(status[0]), 16'h1);
            host_read();
            check("R4 drq cleared by read", 16'({drq, status[1]}), 16'h0);
        end
        check("R8 busy clear at end", 16'(status[0]), 16'h0);
        check("R8 intrq at end", 16'(intrq), 16'h1);
        check("R6 good crc flag", 16'(status[3]), 16'h0);
        check("R5 no lost data", 16'(status[2]), 16'h0);
        check("R7 sector_reg = track", 16'(sector_reg), 16'h27);
        repeat (3) @(negedge clk);
        check("R8 intrq held", 16'(intrq), 16'h1);
        start_cmd();
        check("R1 intrq cleared by command", 16'(intrq), 16'h0);
        // finish this command through not-found
        repeat (6) pulse_index();
    endtask

    task automatic t_fm_badcrc();
        logic [7:0] f [6];
        mfm_mode = 1'b0;
        make_field(1'b0, 8'h11, 8'h00, 8'h09, 8'h01, 1'b1, f);
        start_cmd();
        check("R1 flags cleared", 16'(status[4:2]), 16'h0);
        send_header(1'b0);
        for (int i = 0; i < 6; i++) begin
            send(f[i], 1'b0);
            check("R6 bytes still delivered", 16'(data_reg), 16'(f[i]));
            @(negedge clk) host_wr_data = 1'b1;
            @(negedge clk) host_wr_data = 1'b0;
            check("R4 drq cleared by write", 16'(drq), 16'h0);
        end
        check("R6 crc error set", 16'(status[3]), 16'h1);
        check("R7 sector_reg fm track", 16'(sector_reg), 16'h11);
    endtask

    task automatic t_partial_sync();
        logic [7:0] f [6];
        mfm_mode = 1'b1;
        make_field(1'b1, 8'h33, 8'h00, 8'h01, 8'h03, 1'b0, f);
        start_cmd();
        send(8'hA1, 1'b1); send(8'hA1, 1'b1); send(8'hFE, 1'b1);
        send(8'h55, 1'b0);
        check("R2 two A1 not a header: busy", 16'(status[0]), 16'h1);
        check("R2 two A1 not a header: drq", 16'(drq), 16'h0);
        check("R2 data_reg untouched", 16'(data_reg), 16'h11 ^ 16'h11 ^ 16'(data_reg_prev));
        send(8'hFE, 1'b0);
        send_header(1'b1);
        for (int i = 0; i < 6; i++) begin send(f[i], 1'b0); host_read(); end
        check("R2 full header accepted", 16'(sector_reg), 16'h33);
        check("R6 clean crc", 16'(status[3]), 16'h0);
    endtask

    logic [7:0] data_reg_prev;

    task automatic t_lost();
        logic [7:0] f [6];
        mfm_mode = 1'b1;
        make_field(1'b1, 8'h02, 8'h01, 8'h03, 8'h02, 1'b0, f);
        start_cmd();
        send_header(1'b1);
        send(f[0], 1'b0);
        check("R5 no loss on first byte", 16'(status[2]), 16'h0);
        send(f[1], 1'b0);
        check("R5 lost data set", 16'(status[2]), 16'h1);
        for (int i = 2; i < 6; i++) send(f[i], 1'b0);
        check("R5 lost held to end", 16'(status[2]), 16'h1);
        host_read();
    endtask

    task automatic t_same_cycle();
        logic [7:0] f [6];
        mfm_mode = 1'b1;
        make_field(1'b1, 8'h40, 8'h00, 8'h07, 8'h01, 1'b0, f);
        start_cmd();
        send_header(1'b1);
        send(f[0], 1'b0);
        for (int i = 1; i < 6; i++) begin
            @(negedge clk) begin byte_valid = 1'b1; byte_data = f[i]; host_rd_data = 1'b1; end
            @(negedge clk) begin byte_valid = 1'b0; host_rd_data = 1'b0; end
            check("R5 read with load: drq set", 16'(drq), 16'h1);
            check("R5 read with load: no loss", 16'(status[2]), 16'h0);
        end
        check("R3 last byte", 16'(data_reg), 16'(f[5]));
        host_read();
    endtask

    task automatic t_rnf_and_busy_cmd();
        start_cmd();
        for (int i = 0; i < 3; i++) pulse_index();
        start_cmd();
        check("R10 cmd while busy: busy", 16'(status[0]), 16'h1);
        pulse_index(); pulse_index();
        check("R9 not yet expired", 16'(status[4]), 16'h0);
        check("R9 busy before limit", 16'(status[0]), 16'h1);
        pulse_index();
        check("R10 count not restarted: rnf", 16'(status[4]), 16'h1);
        check("R9 busy cleared", 16'(status[0]), 16'h0);
        check("R9 intrq set", 16'(intrq), 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mfm_good();
        t_fm_badcrc();
        data_reg_prev = data_reg;
        t_partial_sync();
        t_lost();
        t_same_cycle();
        t_rnf_and_busy_cmd();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule